// File: doc/BRIEF.md
# Bound-Register Move Decoder

This block looks at the first bytes of one instruction and decides whether they form the move that copies a lower/upper bound pair between bound registers and memory. It reports the direction of the copy, the register indices on both sides of the ModRM byte, and whether the r/m side names memory. It also raises one invalid-opcode fault flag when the encoding is illegal for the current processor state. That state is given as a processor mode, the code-segment default-size bit, whether an address-size override is in effect, and the REX extension bit for the r/m field. Address generation, segment and canonical checks, paging and alignment belong to other blocks.

Instructions arrive as a window of `WIN_BYTES` bytes on a valid/ready input. Byte 0 is the first byte and sits in bits [7:0]. The window is decoded combinationally and the result is held in one registered output slot, which also has valid/ready. On back-pressure the input is ready only while the slot is empty or is being emptied in the same cycle, so `in_ready = !out_valid || out_ready`. A window is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows on the outputs with `out_valid` high right after that edge. The result stays unchanged until a cycle with `out_ready` high takes it. Nothing is lost or duplicated. Empty and full slot states give one transfer per cycle when the consumer is always ready.

Top module: `bmv_decoder`

## Requirements
- R1: Leading bytes 66h and F0h, in any order, are scanned as prefixes, up to `WIN_BYTES-3` of them. Any other byte ends the scan. The instruction is recognised (`out_rec`=1) only if a 66h was among the prefixes, the next byte is 0Fh, the one after it is 1Ah or 1Bh, and a ModRM byte follows. Otherwise every output field is 0 and `out_fault` is 0.
- R2: Opcode 1Ah gives `out_store`=0: the destination is the reg side and the source is the r/m side. Opcode 1Bh gives `out_store`=1: the destination is the r/m side and the source is the reg side. `out_reg_idx` is ModRM bits [5:3].
- R3: `out_mem` is 1 exactly when ModRM bits [7:6] are not 11b. `out_rm_idx` is ModRM bits [2:0], with bit 3 set to `in_rex_b` in 64-bit mode (`in_mode`=3) and set to 0 in every other mode.
- R4: When an F0h prefix is present, a fault is raised unless the form is a store to memory.
- R5: Outside 64-bit mode, a register r/m operand with index 4 to 7 faults.
- R6: In 64-bit mode, a register r/m operand whose extended index is 4 to 15 faults.
- R7: In protected/compatibility mode (`in_mode`=2), a fault is raised when `in_asz_pfx` equals `in_cs_d`, because that combination gives 16-bit addressing.
- R8: In real mode (`in_mode`=0) and virtual-8086 mode (`in_mode`=1), the same 16-bit-addressing condition faults.
- R9: In 64-bit mode, `in_cs_d` and `in_asz_pfx` never cause a fault.
- R10: When several fault conditions hold at once, the single `out_fault` bit is 1.
- R11: `in_ready` equals `!out_valid || out_ready`. An accepted window's result is valid in the cycle after acceptance and stays stable while `out_ready` is low.
- R12: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Window accepted this cycle if valid |
| in_bytes | input | WIN_BYTES*8 | Instruction bytes, byte 0 in [7:0] |
| in_rex_b | input | 1 | REX extension bit for ModRM r/m |
| in_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit |
| in_cs_d | input | 1 | Code-segment default-size bit |
| in_asz_pfx | input | 1 | Address-size override present |
| out_valid | output | 1 | Result slot full |
| out_ready | input | 1 | Consumer takes the result |
| out_rec | output | 1 | Bound move recognised |
| out_store | output | 1 | 1: r/m side is destination |
| out_reg_idx | output | 3 | ModRM reg index |
| out_rm_idx | output | 4 | Extended ModRM r/m index |
| out_mem | output | 1 | r/m side is memory |
| out_fault | output | 1 | Invalid-opcode fault |

## Verification
The bench builds the block with `WIN_BYTES`=6 and `LEGAL_REGS`=4. The six-byte window gives three prefix slots, so the escape byte can land at every offset from 0 to 3. That reaches 66h and F0h in both orders, a third prefix that pushes the ModRM byte into the last byte, and a foreign prefix that ends the scan early. With four legal registers, the boundary between indices 3 and 4 can be tested in every mode, as well as the REX-extended range up to 15.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  localparam logic [7:0] BYTE_OPSZ  = 8'h66;
  localparam logic [7:0] BYTE_LOCK  = 8'hF0;
  localparam logic [7:0] BYTE_ESC   = 8'h0F;
  localparam logic [7:0] BYTE_LOAD  = 8'h1A;
  localparam logic [7:0] BYTE_STORE = 8'h1B;
  localparam logic [1:0] MOD_IS_REG = 2'b11;

  localparam int REG_IDX_W = 3;
  localparam int RM_IDX_W  = 4;

  typedef struct packed {
    logic                 rec;
    logic                 store;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [RM_IDX_W-1:0]  rm_idx;
    logic                 mem;
    logic                 fault;
  } bmv_result_t;

endpackage

// File: rtl/bmv_prefix_scan.sv
module bmv_prefix_scan
  import bmv_pkg::*;
#(
  parameter int MAX_PFX = 3,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input  logic [MAX_PFX*8-1:0] head,
  output logic [CW-1:0]        pfx_cnt,
  output logic                 has_opsz,
  output logic                 has_lock
);

  logic [MAX_PFX-1:0] run;
  logic [MAX_PFX-1:0] run_opsz;
  logic [MAX_PFX-1:0] run_lock;

  for (genvar i = 0; i < MAX_PFX; i++) begin : g_slot
    logic [7:0] b;
    logic       is_opsz;
    logic       is_lock;
    assign b       = head[8*i +: 8];
    assign is_opsz = (b == BYTE_OPSZ);
    assign is_lock = (b == BYTE_LOCK);
    if (i == 0) begin : g_first
      assign run[i] = is_opsz | is_lock;
    end else begin : g_next
      assign run[i] = run[i-1] & (is_opsz | is_lock);
    end
    assign run_opsz[i] = run[i] & is_opsz;
    assign run_lock[i] = run[i] & is_lock;
  end

  always_comb begin
    pfx_cnt = '0;
    for (int i = 0; i < MAX_PFX; i++) begin
      pfx_cnt = pfx_cnt + CW'(run[i]);
    end
  end

  assign has_opsz = |run_opsz;
  assign has_lock = |run_lock;

endmodule

// File: rtl/bmv_field_decode.sv
module bmv_field_decode
  import bmv_pkg::*;
#(
  parameter int WIN_BYTES = 6,
  localparam int MAX_PFX = WIN_BYTES - 3,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic [CW-1:0]          pfx_cnt,
  input  logic                   has_opsz,
  input  logic                   rex_b,
  input  logic [1:0]             mode,
  output logic                   rec,
  output logic                   store,
  output logic [REG_IDX_W-1:0]   reg_idx,
  output logic [RM_IDX_W-1:0]    rm_idx,
  output logic                   mem
);

  logic [7:0] esc_b;
  logic [7:0] opc_b;
  logic [7:0] modrm_b;
  logic       long_mode;

  always_comb begin
    esc_b   = '0;
    opc_b   = '0;
    modrm_b = '0;
    for (int j = 0; j <= MAX_PFX; j++) begin
      if (pfx_cnt == CW'(j)) begin
        esc_b   = win[8*j      +: 8];
        opc_b   = win[8*(j+1)  +: 8];
        modrm_b = win[8*(j+2)  +: 8];
      end
    end
  end

  assign long_mode = (mode == MODE_LONG);

  assign rec     = has_opsz && (esc_b == BYTE_ESC) &&
                   ((opc_b == BYTE_LOAD) || (opc_b == BYTE_STORE));
  assign store   = (opc_b == BYTE_STORE);
  assign mem     = (modrm_b[7:6] != MOD_IS_REG);
  assign reg_idx = modrm_b[5:3];
  assign rm_idx  = {long_mode & rex_b, modrm_b[2:0]};

endmodule

// File: rtl/bmv_fault_check.sv
module bmv_fault_check
  import bmv_pkg::*;
#(
  parameter int LEGAL_REGS = 4
) (
  input  logic                rec,
  input  logic                store,
  input  logic                mem,
  input  logic [RM_IDX_W-1:0] rm_idx,
  input  logic                has_lock,
  input  logic [1:0]          mode,
  input  logic                cs_d,
  input  logic                asz_pfx,
  output logic                fault
);

  logic lock_bad;
  logic reg_bad;
  logic addr16_bad;
  logic legacy_mode;

  assign legacy_mode = (mode != MODE_LONG);

  // lock is only legal when the written operand is memory
  assign lock_bad   = has_lock && !(store && mem);
  // index range above the architected register count
  assign reg_bad    = !mem && (rm_idx >= RM_IDX_W'(LEGAL_REGS));
  // effective address size of 16 bits in any legacy mode
  assign addr16_bad = legacy_mode && (asz_pfx == cs_d);

  assign fault = rec && (lock_bad || reg_bad || addr16_bad);

endmodule

// File: rtl/bmv_out_stage.sv
module bmv_out_stage #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready = !full_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) begin
        data_q <= in_data;
      end
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;

endmodule

// File: rtl/bmv_decoder.sv
module bmv_decoder
  import bmv_pkg::*;
#(
  parameter int WIN_BYTES  = 6,
  parameter int LEGAL_REGS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIN_BYTES*8-1:0] in_bytes,
  input  logic                   in_rex_b,
  input  logic [1:0]             in_mode,
  input  logic                   in_cs_d,
  input  logic                   in_asz_pfx,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_rec,
  output logic                   out_store,
  output logic [2:0]             out_reg_idx,
  output logic [3:0]             out_rm_idx,
  output logic                   out_mem,
  output logic                   out_fault
);

  localparam int MAX_PFX = WIN_BYTES - 3;
  localparam int CW      = $clog2(MAX_PFX + 1);
  localparam int RES_W   = $bits(bmv_result_t);

  logic [CW-1:0]        pfx_cnt;
  logic                 has_opsz;
  logic                 has_lock;
  logic                 d_rec;
  logic                 d_store;
  logic [REG_IDX_W-1:0] d_reg;
  logic [RM_IDX_W-1:0]  d_rm;
  logic                 d_mem;
  logic                 d_fault;
  bmv_result_t          res_d;
  bmv_result_t          res_q;
  logic [RES_W-1:0]     res_q_bits;

  bmv_prefix_scan #(.MAX_PFX(MAX_PFX)) u_scan (
    .head     (in_bytes[MAX_PFX*8-1:0]),
    .pfx_cnt  (pfx_cnt),
    .has_opsz (has_opsz),
    .has_lock (has_lock)
  );

  bmv_field_decode #(.WIN_BYTES(WIN_BYTES)) u_fields (
    .win      (in_bytes),
    .pfx_cnt  (pfx_cnt),
    .has_opsz (has_opsz),
    .rex_b    (in_rex_b),
    .mode     (in_mode),
    .rec      (d_rec),
    .store    (d_store),
    .reg_idx  (d_reg),
    .rm_idx   (d_rm),
    .mem      (d_mem)
  );

  bmv_fault_check #(.LEGAL_REGS(LEGAL_REGS)) u_fault (
    .rec      (d_rec),
    .store    (d_store),
    .mem      (d_mem),
    .rm_idx   (d_rm),
    .has_lock (has_lock),
    .mode     (in_mode),
    .cs_d     (in_cs_d),
    .asz_pfx  (in_asz_pfx),
    .fault    (d_fault)
  );

  // unrecognised windows report an all-zero record
  always_comb begin
    res_d = '0;
    if (d_rec) begin
      res_d.rec     = 1'b1;
      res_d.store   = d_store;
      res_d.reg_idx = d_reg;
      res_d.rm_idx  = d_rm;
      res_d.mem     = d_mem;
      res_d.fault   = d_fault;
    end
  end

  bmv_out_stage #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q_bits)
  );

  assign res_q       = bmv_result_t'(res_q_bits);
  assign out_rec     = res_q.rec;
  assign out_store   = res_q.store;
  assign out_reg_idx = res_q.reg_idx;
  assign out_rm_idx  = res_q.rm_idx;
  assign out_mem     = res_q.mem;
  assign out_fault   = res_q.fault;

endmodule

// File: rtl/bmv_decoder_chk.sv
module bmv_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_mode,
  input logic       in_cs_d,
  input logic       in_asz_pfx,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_rec,
  input logic       out_store,
  input logic [2:0] out_reg_idx,
  input logic [3:0] out_rm_idx,
  input logic       out_mem,
  input logic       out_fault
);

  assert_reset_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_accept_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_rec, out_store, out_reg_idx, out_rm_idx, out_mem, out_fault})));

  assert_unrec_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rec) |->
      (!out_fault && !out_store && !out_mem && out_rm_idx == 4'd0 && out_reg_idx == 3'd0));

  // covers R5 as well: every legal index is below four in all modes
  assert_reg_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec && !out_mem && out_rm_idx >= 4'd4) |-> out_fault);

  // covers R8 as well: modes 0, 1 and 2 share the rule
  assert_addr16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode != 2'd3 && in_asz_pfx == in_cs_d) |=>
      (!out_rec || out_fault));

endmodule

bind bmv_decoder bmv_decoder_chk u_chk (.*);

// File: tb/sim_bmv_decoder.sv
module sim_bmv_decoder;

  localparam int WB = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WB*8-1:0] in_bytes = '0;
  logic          in_rex_b = 1'b0;
  logic [1:0]    in_mode = 2'd2;
  logic          in_cs_d = 1'b1;
  logic          in_asz_pfx = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_rec, out_store, out_mem, out_fault;
  logic [2:0]    out_reg_idx;
  logic [3:0]    out_rm_idx;

  bmv_decoder #(.WIN_BYTES(WB), .LEGAL_REGS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_rex_b(in_rex_b), .in_mode(in_mode),
    .in_cs_d(in_cs_d), .in_asz_pfx(in_asz_pfx), .out_valid(out_valid),
    .out_ready(out_ready), .out_rec(out_rec), .out_store(out_store),
    .out_reg_idx(out_reg_idx), .out_rm_idx(out_rm_idx), .out_mem(out_mem),
    .out_fault(out_fault)
  );

  always #5ns clk = ~clk;

  int          n_chk = 0;
  int          n_fail = 0;
  int          stall_mode = 0;
  logic        m_valid = 1'b0;
  logic [10:0] m_rec = '0;
  string       m_tag = "R12";
  string       cur_tag = "R1";
  logic        last_acc = 1'b0;
  bit          done = 0;

  function automatic logic [47:0] w6(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                                     logic [7:0] b3, logic [7:0] b4, logic [7:0] b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  // reference: {rec, store, reg[2:0], rm[3:0], mem, fault}
  function automatic logic [10:0] model(logic [47:0] w, logic rex, logic [1:0] mode,
                                        logic csd, logic asz);
    logic [7:0] b [6];
    int k;
    bit opsz, lck, st, mm, f;
    logic [7:0] mrm;
    logic [3:0] rm;
    for (int i = 0; i < 6; i++) b[i] = w[8*i +: 8];
    k = 0; opsz = 0; lck = 0;
    while (k < 3 && (b[k] == 8'h66 || b[k] == 8'hF0)) begin
      if (b[k] == 8'h66) opsz = 1; else lck = 1;
      k++;
    end
    if (!opsz || b[k] != 8'h0F || !(b[k+1] == 8'h1A || b[k+1] == 8'h1B)) return '0;
    mrm = b[k+2];
    st  = (b[k+1] == 8'h1B);
    mm  = (mrm[7:6] != 2'b11);
    rm  = {(mode == 2'd3) ? rex : 1'b0, mrm[2:0]};
    f   = (lck && !(st && mm)) || (!mm && rm >= 4) || (mode != 2'd3 && asz == csd);
    return {1'b1, st, mrm[5:3], rm, mm, f};
  endfunction

  task automatic cycle();
    logic [10:0] got;
    logic exp_rdy;
    bit acc;
    case (stall_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    #1ns;
    got = {out_rec, out_store, out_reg_idx, out_rm_idx, out_mem, out_fault};
    exp_rdy = !m_valid || out_ready;
    n_chk++;
    if (out_valid !== m_valid || in_ready !== exp_rdy) begin
      n_fail++;
      $display("FAIL R11: valid/ready actual=%b/%b expected=%b/%b", out_valid, in_ready,
               m_valid, exp_rdy);
    end else if (m_valid && got !== m_rec) begin
      n_fail++;
      $display("FAIL %s: record actual=%b expected=%b", m_tag, got, m_rec);
    end
    acc = in_valid && exp_rdy;
    if (acc) begin
      m_valid = 1'b1;
      m_rec   = model(in_bytes, in_rex_b, in_mode, in_cs_d, in_asz_pfx);
      m_tag   = cur_tag;
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
    last_acc = acc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(string tag, logic [47:0] w, logic rex, logic [1:0] mode,
                      logic csd, logic asz);
    cur_tag = tag; in_bytes = w; in_rex_b = rex; in_mode = mode;
    in_cs_d = csd; in_asz_pfx = asz; in_valid = 1'b1;
    do cycle(); while (!last_acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_fail++;
      $display("FAIL R11: watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R12: out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(1);
    // R1 recognition
    send("R1", w6(8'hF0, 8'h0F, 8'h1A, 8'hC0, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R1", w6(8'h66, 8'h0F, 8'h1C, 8'hC0, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R1", w6(8'h2E, 8'h66, 8'h0F, 8'h1A, 8'hC0, 8'h00), 0, 2, 1, 0);
    send("R1", w6(8'h66, 8'hF0, 8'h66, 8'h0F, 8'h1B, 8'h05), 0, 2, 1, 0);
    // R2 direction
    send("R2", w6(8'h66, 8'h0F, 8'h1A, 8'hC8, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R2", w6(8'h66, 8'h0F, 8'h1B, 8'h13, 8'h00, 8'h00), 0, 2, 1, 0);
    // R3 memory flag and REX extension
    send("R3", w6(8'h66, 8'h0F, 8'h1A, 8'h42, 8'h00, 8'h00), 1, 3, 0, 0);
    send("R3", w6(8'h66, 8'h0F, 8'h1A, 8'h82, 8'h00, 8'h00), 1, 2, 1, 0);
    // R4 lock
    send("R4", w6(8'hF0, 8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R4", w6(8'hF0, 8'h66, 8'h0F, 8'h1B, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R4", w6(8'h66, 8'hF0, 8'h0F, 8'h1B, 8'hC0, 8'h00), 0, 2, 1, 0);
    // R5 legacy register range
    send("R5", w6(8'h66, 8'h0F, 8'h1A, 8'hC4, 8'h00, 8'h00), 0, 2, 1, 0);
    send("R5", w6(8'h66, 8'h0F, 8'h1A, 8'hC3, 8'h00, 8'h00), 1, 2, 1, 0);
    // R6 64-bit range
    send("R6", w6(8'h66, 8'h0F, 8'h1B, 8'hC3, 8'h00, 8'h00), 0, 3, 0, 0);
    send("R6", w6(8'h66, 8'h0F, 8'h1B, 8'hC4, 8'h00, 8'h00), 0, 3, 0, 0);
    send("R6", w6(8'h66, 8'h0F, 8'h1B, 8'hC0, 8'h00, 8'h00), 1, 3, 0, 0);
    // R7 protected addressing
    send("R7", w6(8'h66, 8'h0F, 8'h1A, 8'hC0, 8'h00, 8'h00), 0, 2, 0, 0);
    send("R7", w6(8'h66, 8'h0F, 8'h1A, 8'hC0, 8'h00, 8'h00), 0, 2, 1, 1);
    send("R7", w6(8'h66, 8'h0F, 8'h1A, 8'hC0, 8'h00, 8'h00), 0, 2, 0, 1);
    // R8 real and virtual-8086
    send("R8", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 0, 0, 0);
    send("R8", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 0, 0, 1);
    send("R8", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 1, 0, 0);
    send("R8", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 1, 0, 1);
    // R9 64-bit ignores addressing inputs
    send("R9", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 3, 0, 0);
    send("R9", w6(8'h66, 8'h0F, 8'h1A, 8'h00, 8'h00, 8'h00), 0, 3, 1, 1);
    // R10 several faults at once
    send("R10", w6(8'hF0, 8'h66, 8'h0F, 8'h1A, 8'hC5, 8'h00), 0, 2, 0, 0);
    idle(2);
    // R11 stall: slot holds while consumer is not ready
    stall_mode = 2;
    send("R11", w6(8'h66, 8'h0F, 8'h1B, 8'hD1, 8'h00, 8'h00), 0, 2, 1, 0);
    in_valid = 1'b1;
    cur_tag = "R11";
    in_bytes = w6(8'h66, 8'h0F, 8'h1A, 8'hC9, 8'h00, 8'h00);
    idle(4);
    stall_mode = 0;
    do cycle(); while (!last_acc);
    in_valid = 1'b0;
    idle(2);
    // random mix with random back-pressure
    stall_mode = 1;
    for (int n = 0; n < 400; n++) begin
      logic [47:0] w;
      int p;
      int np;
      w = {$urandom, $urandom};
      np = $urandom % 4;
      for (int i = 0; i < np; i++) begin
        p = $urandom % 4;
        w[8*i +: 8] = (p < 2) ? 8'h66 : (p == 2) ? 8'hF0 : 8'h2E;
      end
      if ($urandom % 10 != 0) w[8*np +: 8] = 8'h0F;
      p = $urandom % 3;
      w[8*(np+1) +: 8] = (p == 0) ? 8'h1A : (p == 1) ? 8'h1B : 8'h1C;
      send("R10", w, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    stall_mode = 0;
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule